// File: doc/BRIEF.md
# Dual-Clock FIFO with 9/18-Bit Bus Matching

This block is a first-in-first-out buffer that sits between two unrelated clock domains. The write side and the read side each work at either a 9-bit or an 18-bit data width. When the two widths differ, the buffer packs pairs of 9-bit lanes into 18-bit words, or splits 18-bit words into single lanes. An endian select decides which half of an 18-bit word comes first in the lane stream. Both widths and the byte order are taken from configuration pins while reset is held low, and they then stay fixed until the next reset.

Storage is a lane array addressed in 9-bit units. Each side keeps its own lane pointer. A narrow access moves the pointer by one lane and a wide access moves it by two. Each pointer crosses into the other domain as Gray code through a two-flop synchroniser. A wide side codes only its pointer's upper bits, so each step still flips a single bit. Full and empty are computed in lane units against the access size of their own side. A retransmit input rewinds the read side to the first lane written since reset, so the stored data can be replayed.

The intended use is as an elastic buffer between two buses of unequal width, for example a byte stream feeding a halfword consumer, where neither clock may be assumed faster than the other.

Top module: `busmatch_fifo`

## Requirements
- R1: The write width, read width and byte order come from cfg_wr_wide, cfg_rd_wide and cfg_big_endian while rst_n is low. Changing these pins after reset has no effect. A narrow access (pin 0) moves its pointer by one lane and a wide access (pin 1) moves it by two.
- R2: With 9-bit write and 9-bit read, lanes come out in write order. The lane is on rd_data[8:0] and rd_data[17:9] reads 0. wr_data[17:9] is ignored.
- R3: With 18-bit write and 9-bit read, each written word yields two lanes. With cfg_big_endian=1 the first lane is wr_data[17:9]. With cfg_big_endian=0 the first lane is wr_data[8:0].
- R4: With 9-bit write and 18-bit read, two successive lanes form one word. With big-endian order the earlier lane is rd_data[17:9]. With little-endian order the earlier lane is rd_data[8:0].
- R5: With 18-bit write and 18-bit read, words come out unchanged and in order, whatever the byte order.
- R6: wr_full is 1 when fewer free lanes remain than the write access needs (1 or 2). A write request while wr_full is 1 is ignored and stores nothing.
- R7: After reset, rd_empty is 1 and rd_data is 0. rd_empty is 1 when fewer stored lanes exist than the read access needs. A read request while rd_empty is 1 is ignored, and rd_data keeps its value.
- R8: Data written into an empty buffer makes rd_empty fall within 3 read-clock falling edges after the write edge. The delay does not depend on the clock ratio. Pointers cross domains as Gray code that changes by at most one bit per write clock.
- R9: A one-cycle rd_rewind pulse returns the read pointer to lane 0, the first lane written since reset, provided no more than the capacity in lanes has been written since reset. rd_empty reflects the replayed data within 3 read clocks, and later reads return the stored data again from the start.
- R10: Capacity is 2^ADDR_W lanes, which is 2^ADDR_W narrow writes or 2^(ADDR_W-1) wide writes. The occupancy seen by either side never exceeds that capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock, unrelated to wr_clk |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| cfg_wr_wide | input | 1 | Write width select, sampled during reset: 1 = 18-bit, 0 = 9-bit |
| cfg_rd_wide | input | 1 | Read width select, sampled during reset: 1 = 18-bit, 0 = 9-bit |
| cfg_big_endian | input | 1 | Byte order, sampled during reset: 1 = upper half first |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write data; a narrow write uses bits [8:0] |
| wr_full | output | 1 | Not enough room for one write access |
| rd_en | input | 1 | Read request |
| rd_rewind | input | 1 | Retransmit: rewind the read pointer to lane 0 |
| rd_data | output | 18 | Registered read data, updated on each accepted read |
| rd_empty | output | 1 | Not enough data for one read access |

## Verification
On every clock the assertions check these properties:
- Each pointer advances by exactly its sampled access size, and stays put on a refused write or read.
- rd_data changes only on an accepted read.
- A rewind lands the read pointer on lane 0.
- The coded write pointer never changes by more than one bit per write clock.
- Neither side's view of the occupancy passes the capacity.

Lane order under each width and endian pairing cannot be seen by a property, and neither can the fact that refused writes leave no trace in the data. The same holds for the count of accepted writes before full, the wake-up delay after a write into an empty buffer, and the content replayed after a rewind. The bench shows these through its reference model across all eight configurations, with the configuration pins inverted after reset.

// File: rtl/busmatch_fifo_pkg.sv
`timescale 1ns/1ps
package busmatch_fifo_pkg;
  localparam int LANE_W = 9;
  localparam int WORD_W = 2 * LANE_W;

  typedef struct packed {
    logic wr_wide;
    logic rd_wide;
    logic big;
  } port_cfg_t;

  // number of lanes one access moves
  function automatic logic [1:0] lanes_per_access(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/bmf_ptr_sync.sv
`timescale 1ns/1ps
module bmf_ptr_sync #(
  parameter int PW = 6
) (
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic          src_wide,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] meta_q, stable_q;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= gray_in;
      stable_q <= meta_q;
    end
  end

  // a wide source codes only ptr[PW-1:1]; its bit 0 is always zero
  logic [PW-1:0] narrow_bin, wide_bin;
  assign narrow_bin = gray_to_bin(stable_q);
  assign wide_bin   = gray_to_bin({1'b0, stable_q[PW-1:1]});
  assign bin_out    = src_wide ? {wide_bin[PW-2:0], 1'b0} : narrow_bin;
endmodule

// File: rtl/bmf_lane_store.sv
`timescale 1ns/1ps
module bmf_lane_store
  import busmatch_fifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_clk,
  input  logic              we0,
  input  logic              we1,
  input  logic [ADDR_W-1:0] wa0,
  input  logic [ADDR_W-1:0] wa1,
  input  logic [LANE_W-1:0] wd0,
  input  logic [LANE_W-1:0] wd1,
  input  logic [ADDR_W-1:0] ra0,
  input  logic [ADDR_W-1:0] ra1,
  output logic [LANE_W-1:0] rq0,
  output logic [LANE_W-1:0] rq1
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rq0 = mem[ra0];
  assign rq1 = mem[ra1];
endmodule

// File: rtl/bmf_wr_side.sv
`timescale 1ns/1ps
module bmf_wr_side
  import busmatch_fifo_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              cfg_wr_wide,
  input  logic              cfg_rd_wide,
  input  logic              cfg_big,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [PW-1:0]     rptr_sync,
  output logic              wr_full,
  output logic              fire,
  output logic [PW-1:0]     step,
  output logic [PW-1:0]     ptr,
  output logic [PW-1:0]     gray,
  output logic              peer_wide,
  output logic              we0,
  output logic              we1,
  output logic [ADDR_W-1:0] wa0,
  output logic [ADDR_W-1:0] wa1,
  output logic [LANE_W-1:0] wd0,
  output logic [LANE_W-1:0] wd1
);
  localparam int DEPTH = 1 << ADDR_W;

  port_cfg_t cfg_q;
  always_ff @(posedge wr_clk) begin
    if (!rst_n) cfg_q <= '{wr_wide: cfg_wr_wide, rd_wide: cfg_rd_wide, big: cfg_big};
  end
  assign peer_wide = cfg_q.rd_wide;

  function automatic logic [PW-1:0] encode(input logic [PW-1:0] p, input logic wide);
    logic [PW-1:0] h, gh;
    h  = {1'b0, p[PW-1:1]};
    gh = h ^ (h >> 1);
    return wide ? {gh[PW-2:0], 1'b0} : (p ^ (p >> 1));
  endfunction

  logic [PW-1:0] used;
  logic [PW:0]   free_lanes;
  logic [PW-1:0] ptr_nx;

  assign step       = PW'(lanes_per_access(cfg_q.wr_wide));
  assign used       = ptr - rptr_sync;
  assign free_lanes = (PW+1)'(DEPTH) - {1'b0, used};
  assign wr_full    = free_lanes < {1'b0, step};
  assign fire       = wr_en & ~wr_full;
  assign ptr_nx     = ptr + step;

  // lane placement: the first lane goes to the lower address
  assign wa0 = ptr[ADDR_W-1:0];
  assign wa1 = wa0 + 1'b1;
  assign we0 = fire;
  assign we1 = fire & cfg_q.wr_wide;
  assign wd0 = (cfg_q.wr_wide && cfg_q.big) ? wr_data[WORD_W-1:LANE_W] : wr_data[LANE_W-1:0];
  assign wd1 = cfg_q.big ? wr_data[LANE_W-1:0] : wr_data[WORD_W-1:LANE_W];

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      gray <= '0;
    end else if (fire) begin
      ptr  <= ptr_nx;
      gray <= encode(ptr_nx, cfg_q.wr_wide);
    end
  end
endmodule

// File: rtl/bmf_rd_side.sv
`timescale 1ns/1ps
module bmf_rd_side
  import busmatch_fifo_pkg::*;
#(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1
) (
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_wr_wide,
  input  logic              cfg_rd_wide,
  input  logic              cfg_big,
  input  logic              rd_en,
  input  logic              rd_rewind,
  input  logic [PW-1:0]     wptr_sync,
  input  logic [LANE_W-1:0] rq0,
  input  logic [LANE_W-1:0] rq1,
  output logic [ADDR_W-1:0] ra0,
  output logic [ADDR_W-1:0] ra1,
  output logic              rd_empty,
  output logic              fire,
  output logic [PW-1:0]     step,
  output logic [PW-1:0]     ptr,
  output logic [PW-1:0]     gray,
  output logic              peer_wide,
  output logic [WORD_W-1:0] rd_data
);
  port_cfg_t cfg_q;
  always_ff @(posedge rd_clk) begin
    if (!rst_n) cfg_q <= '{wr_wide: cfg_wr_wide, rd_wide: cfg_rd_wide, big: cfg_big};
  end
  assign peer_wide = cfg_q.wr_wide;

  function automatic logic [PW-1:0] encode(input logic [PW-1:0] p, input logic wide);
    logic [PW-1:0] h, gh;
    h  = {1'b0, p[PW-1:1]};
    gh = h ^ (h >> 1);
    return wide ? {gh[PW-2:0], 1'b0} : (p ^ (p >> 1));
  endfunction

  function automatic logic [WORD_W-1:0] assemble(input logic wide, input logic big,
                                                 input logic [LANE_W-1:0] first,
                                                 input logic [LANE_W-1:0] second);
    if (!wide) return {{LANE_W{1'b0}}, first};
    return big ? {first, second} : {second, first};
  endfunction

  logic [PW-1:0] avail;
  logic [PW-1:0] ptr_nx;

  assign step     = PW'(lanes_per_access(cfg_q.rd_wide));
  assign avail    = wptr_sync - ptr;
  assign rd_empty = avail < step;
  assign fire     = rd_en & ~rd_empty & ~rd_rewind;
  assign ra0      = ptr[ADDR_W-1:0];
  assign ra1      = ra0 + 1'b1;
  assign ptr_nx   = rd_rewind ? '0 : ptr + step;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= '0;
      gray    <= '0;
      rd_data <= '0;
    end else begin
      if (rd_rewind || fire) begin
        ptr  <= ptr_nx;
        gray <= encode(ptr_nx, cfg_q.rd_wide);
      end
      if (fire) rd_data <= assemble(cfg_q.rd_wide, cfg_q.big, rq0, rq1);
    end
  end
endmodule

// File: rtl/busmatch_fifo.sv
`timescale 1ns/1ps
module busmatch_fifo
  import busmatch_fifo_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              cfg_wr_wide,
  input  logic              cfg_rd_wide,
  input  logic              cfg_big_endian,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_full,
  input  logic              rd_en,
  input  logic              rd_rewind,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int PW = ADDR_W + 1;

  // named internal events, visible to the bound checker
  logic              wr_fire, rd_fire;
  logic [PW-1:0]     wr_step, rd_step;
  logic [PW-1:0]     wptr, rptr, wptr_gray, rptr_gray;
  logic [PW-1:0]     rptr_in_wr, wptr_in_rd;
  logic              wr_peer_wide, rd_peer_wide;
  logic              we0, we1;
  logic [ADDR_W-1:0] wa0, wa1, ra0, ra1;
  logic [LANE_W-1:0] wd0, wd1, rq0, rq1;

  bmf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n),
    .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .cfg_big(cfg_big_endian),
    .wr_en(wr_en), .wr_data(wr_data), .rptr_sync(rptr_in_wr),
    .wr_full(wr_full), .fire(wr_fire), .step(wr_step), .ptr(wptr), .gray(wptr_gray),
    .peer_wide(wr_peer_wide),
    .we0(we0), .we1(we1), .wa0(wa0), .wa1(wa1), .wd0(wd0), .wd1(wd1)
  );

  bmf_lane_store #(.ADDR_W(ADDR_W)) u_store (
    .wr_clk(wr_clk), .we0(we0), .we1(we1), .wa0(wa0), .wa1(wa1),
    .wd0(wd0), .wd1(wd1), .ra0(ra0), .ra1(ra1), .rq0(rq0), .rq1(rq1)
  );

  bmf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n),
    .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .cfg_big(cfg_big_endian),
    .rd_en(rd_en), .rd_rewind(rd_rewind), .wptr_sync(wptr_in_rd),
    .rq0(rq0), .rq1(rq1), .ra0(ra0), .ra1(ra1),
    .rd_empty(rd_empty), .fire(rd_fire), .step(rd_step), .ptr(rptr), .gray(rptr_gray),
    .peer_wide(rd_peer_wide), .rd_data(rd_data)
  );

  bmf_ptr_sync #(.PW(PW)) u_wsync (
    .dst_clk(rd_clk), .rst_n(rst_n), .src_wide(rd_peer_wide),
    .gray_in(wptr_gray), .bin_out(wptr_in_rd)
  );

  bmf_ptr_sync #(.PW(PW)) u_rsync (
    .dst_clk(wr_clk), .rst_n(rst_n), .src_wide(wr_peer_wide),
    .gray_in(rptr_gray), .bin_out(rptr_in_wr)
  );
endmodule

// File: rtl/busmatch_fifo_chk.sv
`timescale 1ns/1ps
module busmatch_fifo_chk #(
  parameter int ADDR_W = 5,
  localparam int PW = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_full,
  input logic          rd_en,
  input logic          rd_rewind,
  input logic          rd_empty,
  input logic [17:0]   rd_data,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wr_step,
  input logic [PW-1:0] rd_step,
  input logic [PW-1:0] wptr_gray,
  input logic [PW-1:0] rptr_in_wr,
  input logic [PW-1:0] wptr_in_rd
);
  logic [PW-1:0] occ_wr, occ_rd;
  assign occ_wr = wptr - rptr_in_wr;
  assign occ_rd = wptr_in_rd - rptr;

  p_wr_step_r1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_fire |=> (wptr == $past(wptr) + $past(wr_step)));

  p_rd_step_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_fire |=> (rptr == $past(rptr) + $past(rd_step)));

  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && wr_full) |=> $stable(wptr));

  p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (rd_en && rd_empty && !rd_rewind) |=> $stable(rptr));

  p_data_hold_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));

  p_gray_onebit_r8: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wptr_gray ^ $past(wptr_gray)) <= 1);

  p_rewind_r9: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_rewind |=> (rptr == '0));

  p_room_wr_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
    {1'b0, occ_wr} <= (PW+1)'(DEPTH));

  p_room_rd_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    {1'b0, occ_rd} <= (PW+1)'(DEPTH));
endmodule

bind busmatch_fifo busmatch_fifo_chk #(.ADDR_W(ADDR_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
  .wr_en(wr_en), .wr_full(wr_full), .rd_en(rd_en), .rd_rewind(rd_rewind),
  .rd_empty(rd_empty), .rd_data(rd_data),
  .wr_fire(wr_fire), .rd_fire(rd_fire), .wptr(wptr), .rptr(rptr),
  .wr_step(wr_step), .rd_step(rd_step), .wptr_gray(wptr_gray),
  .rptr_in_wr(rptr_in_wr), .wptr_in_rd(wptr_in_rd)
);

// File: tb/busmatch_fifo_test.sv
`timescale 1ns/1ps
module busmatch_fifo_test;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;

  logic        wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic        cfg_wr_wide = 0, cfg_rd_wide = 0, cfg_big_endian = 0;
  logic        wr_en = 0, rd_en = 0, rd_rewind = 0;
  logic [17:0] wr_data = '0;
  logic [17:0] rd_data;
  logic        wr_full, rd_empty;

  busmatch_fifo #(.ADDR_W(AW)) uut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n),
    .cfg_wr_wide(cfg_wr_wide), .cfg_rd_wide(cfg_rd_wide), .cfg_big_endian(cfg_big_endian),
    .wr_en(wr_en), .wr_data(wr_data), .wr_full(wr_full),
    .rd_en(rd_en), .rd_rewind(rd_rewind), .rd_data(rd_data), .rd_empty(rd_empty)
  );

  always #4    wr_clk = ~wr_clk;   // 125 MHz
  always #5.5  rd_clk = ~rd_clk;   // unrelated read clock

  int checks = 0, fails = 0, kseq = 0;
  bit ww, rw, big;
  logic [8:0] model[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string mode_tag();
    if (!ww && !rw) return "R2";
    if (ww && !rw)  return "R3";
    if (!ww && rw)  return "R4";
    return "R5";
  endfunction

  function automatic logic [17:0] item(input int k);
    return 18'(k * 2731 + 417);
  endfunction

  task automatic push_item(input logic [17:0] d);
    if (!ww) model.push_back(d[8:0]);
    else if (big) begin model.push_back(d[17:9]); model.push_back(d[8:0]); end
    else begin model.push_back(d[8:0]); model.push_back(d[17:9]); end
  endtask

  task automatic do_reset();
    wr_en = 0; rd_en = 0; rd_rewind = 0;
    cfg_wr_wide = ww; cfg_rd_wide = rw; cfg_big_endian = big;
    rst_n = 0;
    repeat (4) @(posedge rd_clk);
    repeat (3) @(posedge wr_clk);
    @(negedge wr_clk) rst_n = 1;
    // R1: flip the pins after reset; the design must keep the sampled values
    cfg_wr_wide = ~ww; cfg_rd_wide = ~rw; cfg_big_endian = ~big;
    model.delete();
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic wr_one(input logic [17:0] d, output bit took);
    @(negedge wr_clk);
    if (!wr_full) begin
      wr_en = 1; wr_data = d; took = 1; push_item(d);
      @(negedge wr_clk) wr_en = 0;
    end else took = 0;
  endtask

  task automatic rd_one(input string tag, output bit took);
    logic [17:0] exp;
    logic [8:0]  b0, b1;
    @(negedge rd_clk);
    if (rd_empty) begin took = 0; return; end
    rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    took = 1;
    if (model.size() < (rw ? 2 : 1)) begin
      check(0, tag, "read beyond model", int'(rd_data), 0);
      return;
    end
    b0 = model.pop_front();
    if (rw) begin
      b1 = model.pop_front();
      exp = big ? {b0, b1} : {b1, b0};
    end else exp = {9'd0, b0};
    check(rd_data == exp, tag, "read data", int'(rd_data), int'(exp));
  endtask

  task automatic drain(input string tag, output int lanes);
    bit took;
    lanes = 0;
    for (int i = 0; i < 4 * DEPTH; i++) begin
      rd_one(tag, took);
      if (!took) break;
      lanes += rw ? 2 : 1;
    end
  endtask

  task automatic run_config();
    bit took;
    int lat, lanes, accepted;
    logic [17:0] last;
    do_reset();
    check(rd_empty == 1, "R7", "empty after reset", int'(rd_empty), 1);
    check(wr_full == 0, "R6", "full after reset", int'(wr_full), 0);
    check(rd_data == 0, "R7", "rd_data after reset", int'(rd_data), 0);

    // R8: wake-up delay after writing into an empty buffer
    for (int i = 0; i < ((!ww && rw) ? 2 : 1); i++) begin
      wr_one(item(kseq), took); kseq++;
    end
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge rd_clk); lat++;
      if (!rd_empty) break;
    end
    check(lat <= 3, "R8", "read edges until not empty", lat, 3);
    drain(mode_tag(), lanes);
    check(model.size() == 0, mode_tag(), "model left after first drain", model.size(), 0);

    // R10 / R1: fill to full with the pins inverted
    repeat (6) @(negedge wr_clk);
    accepted = 0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      wr_one(item(kseq), took);
      if (!took) break;
      kseq++; accepted++;
    end
    check(accepted == DEPTH / (ww ? 2 : 1), "R1 R10", "writes accepted until full",
          accepted, DEPTH / (ww ? 2 : 1));
    check(wr_full == 1, "R6", "full after fill", int'(wr_full), 1);

    // R6: write while full is dropped
    @(negedge wr_clk) begin wr_en = 1; wr_data = 18'h3FFFF; end
    @(negedge wr_clk) wr_en = 0;
    check(wr_full == 1, "R6", "full after refused write", int'(wr_full), 1);

    repeat (6) @(negedge rd_clk);
    drain(mode_tag(), lanes);
    check(lanes == DEPTH, "R10", "lanes drained", lanes, DEPTH);
    check(model.size() == 0, "R6", "refused write left no data", model.size(), 0);

    // R7: read while empty leaves rd_data alone
    last = rd_data;
    @(negedge rd_clk) rd_en = 1;
    @(negedge rd_clk) rd_en = 0;
    check(rd_data == last, "R7", "rd_data after empty read", int'(rd_data), int'(last));
    check(rd_empty == 1, "R7", "empty after drain", int'(rd_empty), 1);
  endtask

  task automatic run_rewind();
    bit took;
    int lat, lanes;
    logic [17:0] saved [4];
    do_reset();
    for (int i = 0; i < 4; i++) begin
      saved[i] = item(kseq); kseq++;
      wr_one(saved[i], took);
    end
    repeat (6) @(negedge rd_clk);
    drain(mode_tag(), lanes);
    @(negedge rd_clk) rd_rewind = 1;
    @(negedge rd_clk) rd_rewind = 0;
    lat = 0;
    while (rd_empty && lat < 10) begin @(negedge rd_clk); lat++; end
    check(lat <= 3, "R9", "read clocks until replay visible", lat, 3);
    model.delete();
    for (int i = 0; i < 4; i++) push_item(saved[i]);
    drain("R9", lanes);
    check(lanes == (ww ? 8 : 4), "R9", "lanes replayed", lanes, ww ? 8 : 4);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < 8; c++) begin
      ww = c[0]; rw = c[1]; big = c[2];
      run_config();
      run_rewind();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule